// File: doc/BRIEF.md
# Byte Memory with Built-in Test and Spare-Column Repair

This block is a 64-byte local memory built from two independent banks of 32 words. The most significant address bit selects the bank. Each stored word is nine bits wide: eight data columns plus one spare column. A built-in test sequencer runs on its own when reset is released, and again whenever `test_start` is pulsed, for example when logic elsewhere has seen a memory error.

The sequencer visits every byte location in turn. At each location it writes four patterns and reads each one back: all zeros, all ones, 0x55 and 0xAA. The spare column is written with bit 0 of each pattern. Any bit that reads back wrong marks its column as bad in that bank. When the test ends, each bank latches a repair selection, which is a valid bit plus a 3-bit column index. After that, writes copy the data bit of the repaired column into the spare, and reads take that bit from the spare instead. A bank with two or more bad columns (the spare counts as a column) raises `fatal`.

Normal access uses a valid/ready request channel and a valid/ready read-response channel:
- A request moves on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low while the test runs.
- `req_ready` is also low while a read response is waiting with `rsp_ready` low.
- A response holds its data until it is taken.
- Writes produce no response.

The `stuck_mask` input holds every masked cell at zero on readback. It is there to inject faults for verification.

Top module: `sparecol_mem`

## Requirements
- R1: While reset is held, `busy`=1, `done`=0, `fatal`=0, `rsp_valid`=0 and `req_ready`=0. After reset is released, the test runs without any request. `busy` then falls between 510 and 520 cycles later, and `done` rises at the same time.
- R2: With no injected fault, a read of byte address A (bank = A[5], row = A[4:0]) returns the last byte written to A.
- R3: One stuck data column in a bank is repaired after a test. Reads then return written data for every value, and `fatal` stays 0.
- R4: The two banks are repaired independently. One stuck data column in each bank at the same time is repaired in both, with `fatal`=0.
- R5: A stuck spare column with no bad data column leaves `fatal`=0 and reads correct.
- R6: Two bad columns in one bank raise `fatal`=1 once `done` is set. This includes a bad spare together with a bad data column.
- R7: `test_start` while idle reruns the test. `busy`=1 and `done`=0 from the next cycle, `fatal` and the repairs are recomputed from the new results, and the run takes 510 to 520 cycles.
- R8: While `busy`=1, requests are not accepted: `req_ready`=0 and no response appears. A write offered during a test leaves no trace. After a fault-free test, every location holds the last test pattern 0xAA.
- R9: A pending response keeps `rsp_valid` and `rsp_data` stable while `rsp_ready`=0, and `req_ready` stays 0 meanwhile. A write produces no response.
- R10: `test_start` while `busy`=1 is ignored and the run is not lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the test starts when it is released |
| test_start | input | 1 | Pulse to rerun the test; honoured only when idle |
| busy | output | 1 | Test in progress |
| done | output | 1 | Last test finished; repairs are valid |
| fatal | output | 1 | A bank has two or more bad columns |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address; bit 5 picks the bank |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |
| stuck_mask | input | 18 | Stuck-at-0 cell mask; bits [8:0] bank 0, [17:9] bank 1; bit 8 of each group is the spare |

## Verification
The bench injects a stuck data column in each bank and checks that every location reads back correctly afterwards. A design that steered the spare into the wrong position, or forgot to copy the data bit into the spare on writes, would return corrupted bytes. It also pairs a bad spare with a bad data column: a design that ignores spare faults would "repair" onto a dead cell and keep `fatal` low. Requests are offered during a test, and a second start is pulsed mid-test. A design that let them through would overwrite the final 0xAA pattern, and one that restarted would run long. Back-pressure checks catch response data that changes, or new requests accepted, while a response is pending.

// File: rtl/sparecol_pkg.sv
package sparecol_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_CMP  = 2'd2,
    ST_FIN  = 2'd3
  } bist_st_e;

  localparam int NUM_PAT = 4;
endpackage

// File: rtl/sc_bank_array.sv
module sc_bank_array #(
  parameter int ROWS = 32,
  parameter int CW   = 9,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] addr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] stuck,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  // stuck cells read back as zero
  assign rdata = cells[addr] & ~stuck;
endmodule

// File: rtl/sc_col_steer.sv
module sc_col_steer #(
  parameter int DW  = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          rep_ok,
  input  logic [IW-1:0] rep_col,
  input  logic [DW-1:0] wbyte,
  input  logic [DW:0]   raw,
  output logic [DW:0]   wword,
  output logic [DW-1:0] rbyte
);
  assign wword = {(rep_ok ? wbyte[rep_col] : 1'b0), wbyte};

  for (genvar i = 0; i < DW; i++) begin : g_col
    assign rbyte[i] = (rep_ok && rep_col == IW'(i)) ? raw[DW] : raw[i];
  end
endmodule

// File: rtl/sc_bist.sv
module sc_bist
  import sparecol_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BANKS = 2,
  parameter int ROWS  = 32,
  localparam int CW   = DW + 1,
  localparam int AW   = $clog2(BANKS * ROWS),
  localparam int BW   = $clog2(BANKS),
  localparam int IW   = $clog2(DW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CW-1:0]       rd_word,
  output logic                busy,
  output logic                done,
  output logic                fatal,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [CW-1:0]       mem_wdata,
  output logic [BANKS-1:0]    rep_ok,
  output logic [BANKS*IW-1:0] rep_col
);
  bist_st_e      st;
  logic [AW-1:0] addr_q;
  logic [1:0]    pat_q;
  logic [CW-1:0] bad_q [BANKS];
  logic [DW-1:0] pat;
  logic [CW-1:0] expw;
  logic [BW-1:0] bank;

  logic [BANKS-1:0]    fin_ok;
  logic [BANKS*IW-1:0] fin_col;
  logic                fin_fatal;

  always_comb begin
    for (int j = 0; j < DW; j++) begin
      case (pat_q)
        2'd0:    pat[j] = 1'b0;
        2'd1:    pat[j] = 1'b1;
        2'd2:    pat[j] = (j % 2 == 0);
        default: pat[j] = (j % 2 == 1);
      endcase
    end
  end

  assign expw      = {pat[0], pat};
  assign bank      = addr_q[AW-1 -: BW];
  assign busy      = (st != ST_IDLE);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = expw;

  // per-bank repair decision from accumulated bad-column masks
  always_comb begin
    fin_fatal = 1'b0;
    fin_ok    = '0;
    fin_col   = '0;
    for (int b = 0; b < BANKS; b++) begin
      if ($countones(bad_q[b]) > 1) fin_fatal = 1'b1;
      if ($countones(bad_q[b]) == 1 && !bad_q[b][DW]) begin
        fin_ok[b] = 1'b1;
        for (int c = 0; c < DW; c++)
          if (bad_q[b][c]) fin_col[b*IW +: IW] = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_WR;
      addr_q  <= '0;
      pat_q   <= '0;
      done    <= 1'b0;
      fatal   <= 1'b0;
      rep_ok  <= '0;
      rep_col <= '0;
      for (int b = 0; b < BANKS; b++) bad_q[b] <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_WR;
          addr_q  <= '0;
          pat_q   <= '0;
          done    <= 1'b0;
          fatal   <= 1'b0;
          rep_ok  <= '0;
          rep_col <= '0;
          for (int b = 0; b < BANKS; b++) bad_q[b] <= '0;
        end
        ST_WR: st <= ST_CMP;
        ST_CMP: begin
          bad_q[bank] <= bad_q[bank] | (rd_word ^ expw);
          if (pat_q == 2'(NUM_PAT - 1)) begin
            pat_q <= '0;
            if (addr_q == AW'(BANKS * ROWS - 1)) st <= ST_FIN;
            else begin
              addr_q <= addr_q + 1'b1;
              st     <= ST_WR;
            end
          end else begin
            pat_q <= pat_q + 1'b1;
            st    <= ST_WR;
          end
        end
        default: begin
          st      <= ST_IDLE;
          done    <= 1'b1;
          fatal   <= fin_fatal;
          rep_ok  <= fin_ok;
          rep_col <= fin_col;
        end
      endcase
    end
  end

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r6_fatal_after_test: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> done);
  a_r7_start_reruns: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done && !fatal));
  a_r3_repair_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rep_ok) && $stable(rep_col)));
endmodule

// File: rtl/sparecol_mem.sv
module sparecol_mem #(
  parameter int DW    = 8,
  parameter int BANKS = 2,
  parameter int ROWS  = 32,
  localparam int CW   = DW + 1,
  localparam int AW   = $clog2(BANKS * ROWS),
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int IW   = $clog2(DW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_start,
  output logic                busy,
  output logic                done,
  output logic                fatal,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_data,
  input  logic [BANKS*CW-1:0] stuck_mask
);
  logic                b_we;
  logic [AW-1:0]       b_addr;
  logic [CW-1:0]       b_wdata;
  logic [BANKS-1:0]    rep_ok;
  logic [BANKS*IW-1:0] rep_col;
  logic [AW-1:0]       m_addr;
  logic [BW-1:0]       m_bank;
  logic                accept;
  logic [CW-1:0]       raw   [BANKS];
  logic [CW-1:0]       wword [BANKS];
  logic [DW-1:0]       rbyte [BANKS];

  assign req_ready = !busy && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign m_addr    = busy ? b_addr : req_addr;
  assign m_bank    = m_addr[AW-1 -: BW];

  sc_bist #(.DW(DW), .BANKS(BANKS), .ROWS(ROWS)) u_bist (
    .clk(clk), .rst_n(rst_n), .start(test_start), .rd_word(raw[m_bank]),
    .busy(busy), .done(done), .fatal(fatal), .mem_we(b_we),
    .mem_addr(b_addr), .mem_wdata(b_wdata), .rep_ok(rep_ok), .rep_col(rep_col)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          we_b;
    logic [CW-1:0] wd_b;

    assign we_b = (m_bank == BW'(b)) &&
                  (busy ? b_we : (accept && req_write));
    assign wd_b = busy ? b_wdata : wword[b];

    sc_col_steer #(.DW(DW)) u_steer (
      .rep_ok(rep_ok[b]), .rep_col(rep_col[b*IW +: IW]), .wbyte(req_wdata),
      .raw(raw[b]), .wword(wword[b]), .rbyte(rbyte[b])
    );

    sc_bank_array #(.ROWS(ROWS), .CW(CW)) u_array (
      .clk(clk), .we(we_b), .addr(m_addr[RW-1:0]), .wdata(wd_b),
      .stuck(stuck_mask[b*CW +: CW]), .rdata(raw[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rbyte[m_bank];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r8_no_rsp_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> !rsp_valid);
  a_r9_write_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && (!rsp_valid || rsp_ready)) |=> !rsp_valid);
endmodule

// File: tb/sparecol_mem_tb.sv
module sparecol_mem_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_start = 1'b0;
  logic        busy, done, fatal;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [17:0] stuck_mask = '0;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_mem [64];
  logic [7:0] exp_q [$];
  string cur_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  sparecol_mem u_dut (
    .clk(clk), .rst_n(rst_n), .test_start(test_start), .busy(busy),
    .done(done), .fatal(fatal), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .stuck_mask(stuck_mask)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each consumed response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected response"}, rsp_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, {cur_tag, " read data"}, rsp_data, e);
      end
    end
  end

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    exp_mem[a] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(exp_mem[a]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill_and_read(input int seed, input string tag);
    cur_tag = tag;
    for (int a = 0; a < 64; a++) do_write(a, 8'((a * 37 + seed) ^ (a[0] ? 8'hFF : 8'h00)));
    for (int a = 0; a < 64; a++) do_read(a);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {tag, " all responses seen"}, exp_q.size(), 0);
  endtask

  task automatic run_test(input logic [17:0] mask, input bit hold_req,
                          input bit mid_start, output int cyc);
    bit saw_ready, saw_rsp;
    saw_ready = 0; saw_rsp = 0; cyc = 0;
    @(negedge clk);
    stuck_mask = mask; test_start = 1'b1;
    @(negedge clk);
    test_start = 1'b0;
    check(busy && !done && !fatal, "R7 restart state", {busy, done, fatal}, 3'b100);
    if (hold_req) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd0; req_wdata = 8'h3C;
    end
    while (busy && cyc < 2000) begin
      if (req_ready) saw_ready = 1;
      if (rsp_valid) saw_rsp = 1;
      cyc++;
      test_start = (mid_start && cyc == 100);
      @(negedge clk);
    end
    req_valid = 1'b0; test_start = 1'b0;
    if (hold_req) begin
      check(!saw_ready, "R8 req_ready low while busy", saw_ready, 0);
      check(!saw_rsp, "R8 no response while busy", saw_rsp, 0);
    end
    check(done && !busy, "R7 done after rerun", {busy, done}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check(busy && !done && !fatal && !rsp_valid && !req_ready, "R1 reset state",
          {busy, done, fatal, rsp_valid, req_ready}, 5'b10000);
    rst_n = 1'b1;
    cyc = 0;
    @(negedge clk);
    while (busy && cyc < 2000) begin cyc++; @(negedge clk); end
    check(cyc >= 510 && cyc <= 520, "R1 power-up test length", cyc, 513);
    check(done && !fatal, "R1 done after power-up", {done, fatal}, 2'b10);

    fill_and_read(11, "R2");

    // R9: back-pressure and write without response
    cur_tag = "R9";
    rsp_ready = 1'b0;
    do_read(5);
    for (int i = 0; i < 3; i++) begin
      check(rsp_valid && rsp_data == exp_mem[5], "R9 held response", rsp_data, exp_mem[5]);
      check(!req_ready, "R9 req_ready low while pending", req_ready, 0);
      @(negedge clk);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R9 response consumed", exp_q.size(), 0);
    do_write(9, 8'h5A);
    repeat (2) begin
      @(negedge clk);
      check(!rsp_valid, "R9 write gives no response", rsp_valid, 0);
    end

    // R8, R10: fault-free rerun with a blocked write and a mid-test start
    run_test(18'h0, 1'b1, 1'b1, cyc);
    check(cyc >= 510 && cyc <= 520, "R10 mid-test start ignored", cyc, 513);
    check(!fatal, "R8 no fatal", fatal, 0);
    for (int a = 0; a < 64; a++) exp_mem[a] = 8'hAA;
    cur_tag = "R8";
    do_read(0); do_read(40);
    repeat (3) @(negedge clk);

    // R3: single stuck data column in bank 0
    run_test(18'h00008, 1'b0, 1'b0, cyc);
    check(!fatal, "R3 no fatal with one bad column", fatal, 0);
    fill_and_read(99, "R3");

    // R4: one bad column in each bank
    run_test(18'h08000 | 18'h00001, 1'b0, 1'b0, cyc);
    check(!fatal, "R4 no fatal, both banks repaired", fatal, 0);
    fill_and_read(200, "R4");

    // R5: bad spare only in bank 1
    run_test(18'h20000, 1'b0, 1'b0, cyc);
    check(!fatal, "R5 bad spare alone not fatal", fatal, 0);
    fill_and_read(57, "R5");

    // R6: two bad data columns in bank 0
    run_test(18'h00022, 1'b0, 1'b0, cyc);
    check(fatal && done, "R6 two data columns fatal", {fatal, done}, 2'b11);
    // R6: bad spare plus bad data column in bank 1
    run_test(18'h20000 | 18'h00800, 1'b0, 1'b0, cyc);
    check(fatal && done, "R6 spare plus data fatal", {fatal, done}, 2'b11);

    // R7: clean rerun clears fatal and repairs
    run_test(18'h0, 1'b0, 1'b0, cyc);
    check(!fatal, "R7 fatal cleared on rerun", fatal, 0);
    check(cyc >= 510 && cyc <= 520, "R7 rerun length", cyc, 513);
    fill_and_read(3, "R7");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule